// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Overflow-Safe Set-Less-Than

This block is a purely combinational integer arithmetic/logic unit. It is assembled from a row of identical one-bit slices. Each slice can optionally invert either operand bit. It forms the AND, the OR and a full-adder sum of the two bits, then picks one of these, or a "less" input, with a four-way select. The carries ripple from the least significant slice to the most significant one. A flag stage at the top of the word produces the overflow indication and a "set" bit, which is routed back into slice 0.

The caller supplies two operands and a 4-bit control word. The most significant control bit inverts operand a. The next bit inverts operand b and also sets the carry into bit 0. The low two bits choose the slice output. The block returns the result word, a zero flag, a signed overflow flag and the carry out of the top slice. The result settles combinationally. Any register stages belong to the surrounding datapath.

Top module: `alu_bitslice`

## Requirements
- R1: Control 4'b0000 (AND) gives result = a & b.
- R2: Control 4'b0001 (OR) gives result = a | b.
- R3: Control 4'b0010 (add) gives result = (a + b) mod 2^WIDTH, and carry_o equals bit WIDTH of the unsigned sum a + b.
- R4: Control 4'b0110 (subtract) gives result = (a - b) mod 2^WIDTH, computed as a + ~b + 1. carry_o is therefore 1 exactly when a >= b as unsigned numbers.
- R5: Control 4'b0111 (set-less-than) gives result bit 0 = 1 when a < b as signed two's complement, and 0 otherwise. All upper bits are 0. The outcome stays correct when a - b overflows, for example a = most-negative and b = 1.
- R6: Control 4'b1100 (NOR) gives result = ~(a | b).
- R7: zero_o is 1 exactly when every result bit is 0, under every control code.
- R8: overflow_o is the signed overflow of the internal sum x + y + cin, under every control code. Here x is a or ~a (control bit 3), y is b or ~b (control bit 2), and cin equals control bit 2. For add and subtract, this is the signed overflow of a + b and a - b.
- R9: The remaining control codes follow the slice structure with no separate decoding. Control bits [1:0] = 0 give x & y, 1 gives x | y, 2 gives the sum x + y + cin, and 3 gives bit 0 = (sign of that sum XOR overflow) with the upper bits 0. For example, 4'b1101 yields NAND.
- R10: carry_o is bit WIDTH of x + y + cin under every control code, including the logical ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand a |
| b_i | input | WIDTH | Operand b |
| ctrl_i | input | 4 | {invert a, negate b, select[1:0]} |
| result_o | output | WIDTH | Selected slice outputs |
| zero_o | output | 1 | High when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow of the internal adder |
| carry_o | output | 1 | Carry out of the most significant slice |

## Verification
The block holds no state, so a broken carry link, a wrong invert path or a bad set feedback shows up at the outputs for the same input vector that exercises it. No delay is involved. A break in the ripple chain shows only on operands whose carries travel past the broken slice. For this reason the vectors include all-ones plus one, the most-negative and most-positive values, and equal operands. A wrong set-less-than correction shows only when a - b overflows, so pairs that straddle the signed range are applied on purpose. Every output is compared against a reference computed from plain integer arithmetic, for all sixteen control codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } slice_sel_e;

    typedef struct packed {
        logic       inv_a;
        logic       neg_b;
        slice_sel_e sel;
    } alu_ctrl_t;

    localparam logic [3:0] CTRL_AND = 4'b0000;
    localparam logic [3:0] CTRL_OR  = 4'b0001;
    localparam logic [3:0] CTRL_ADD = 4'b0010;
    localparam logic [3:0] CTRL_SUB = 4'b0110;
    localparam logic [3:0] CTRL_SLT = 4'b0111;
    localparam logic [3:0] CTRL_NOR = 4'b1100;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_a_i,
    input  logic       inv_b_i,
    input  logic       carry_i,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    output logic       res_o,
    output logic       sum_o,
    output logic       carry_o
);

    typedef struct packed {
        logic x;
        logic y;
        logic g_and;
        logic g_or;
        logic sum;
        logic cout;
        logic res;
    } slice_t;

    slice_t s_d;

    always_comb begin
        s_d       = '0;
        s_d.x     = inv_a_i ? ~a_i : a_i;
        s_d.y     = inv_b_i ? ~b_i : b_i;
        s_d.g_and = s_d.x & s_d.y;
        s_d.g_or  = s_d.x | s_d.y;
        s_d.sum   = s_d.x ^ s_d.y ^ carry_i;
        s_d.cout  = (s_d.x & s_d.y) | (s_d.x & carry_i) | (s_d.y & carry_i);
        unique case (sel_i)
            SEL_AND:  s_d.res = s_d.g_and;
            SEL_OR:   s_d.res = s_d.g_or;
            SEL_SUM:  s_d.res = s_d.sum;
            SEL_LESS: s_d.res = less_i;
            default:  s_d.res = 1'b0;
        endcase
    end

    assign res_o   = s_d.res;
    assign sum_o   = s_d.sum;
    assign carry_o = s_d.cout;

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] result_i,
    input  logic             msb_carry_in_i,
    input  logic             msb_carry_out_i,
    input  logic             msb_sum_i,
    output logic             zero_o,
    output logic             overflow_o,
    output logic             set_o
);

    typedef struct packed {
        logic zero;
        logic ovf;
        logic set;
    } flags_t;

    flags_t f_d;

    always_comb begin
        f_d      = '0;
        f_d.zero = ~(|result_i);
        f_d.ovf  = msb_carry_in_i ^ msb_carry_out_i;
        f_d.set  = msb_sum_i ^ f_d.ovf;
    end

    assign zero_o     = f_d.zero;
    assign overflow_o = f_d.ovf;
    assign set_o      = f_d.set;

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       ctrl_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             overflow_o,
    output logic             carry_o
);

    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl_d;
    logic [WIDTH:0]   chain_d;
    logic [WIDTH-1:0] res_d;
    logic [WIDTH-1:0] sum_d;
    logic             set_d;
    logic             unused_sum_bits;

    assign ctrl_d     = alu_ctrl_t'(ctrl_i);
    assign chain_d[0] = ctrl_d.neg_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_w;
        if (i == 0) begin : g_lsb
            assign less_w = set_d;
        end else begin : g_upper
            assign less_w = 1'b0;
        end

        alu_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (ctrl_d.inv_a),
            .inv_b_i (ctrl_d.neg_b),
            .carry_i (chain_d[i]),
            .less_i  (less_w),
            .sel_i   (ctrl_d.sel),
            .res_o   (res_d[i]),
            .sum_o   (sum_d[i]),
            .carry_o (chain_d[i+1])
        );
    end

    assign unused_sum_bits = ^sum_d[MSB-1:0];

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .result_i        (res_d),
        .msb_carry_in_i  (chain_d[MSB]),
        .msb_carry_out_i (chain_d[WIDTH]),
        .msb_sum_i       (sum_d[MSB]),
        .zero_o          (zero_o),
        .overflow_o      (overflow_o),
        .set_o           (set_d)
    );

    assign result_o = res_d;
    assign carry_o  = chain_d[WIDTH];

endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [3:0]       ctrl_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             overflow_o,
    input logic             carry_o
);

    localparam int MSB = WIDTH - 1;

    always_comb begin
        assert_zero_flag_R7: assert (zero_o == (result_o == '0))
            else $error("zero flag disagrees with result");

        if (ctrl_i == CTRL_SLT) begin
            assert_slt_upper_clear_R5: assert (result_o[MSB:1] == '0)
                else $error("set-less-than upper bits not clear");
        end

        if (ctrl_i == CTRL_ADD) begin
            assert_add_value_R3: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}))
                else $error("add result or carry wrong");
            assert_add_overflow_R8: assert (overflow_o ==
                ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
                else $error("add overflow wrong");
        end

        if (ctrl_i == CTRL_SUB) begin
            assert_sub_overflow_R8: assert (overflow_o ==
                ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
                else $error("subtract overflow wrong");
        end

        if (ctrl_i == CTRL_NOR) begin
            assert_nor_value_R6: assert (result_o == ~(a_i | b_i))
                else $error("nor result wrong");
        end
    end

endmodule

bind alu_bitslice alu_bitslice_chk #(.WIDTH(WIDTH)) chk_i (
    .a_i        (a_i),
    .b_i        (b_i),
    .ctrl_i     (ctrl_i),
    .result_o   (result_o),
    .zero_o     (zero_o),
    .overflow_o (overflow_o),
    .carry_o    (carry_o)
);

// File: tb/alu_bitslice_tb_top.sv
`timescale 1ns/1ps
module alu_bitslice_tb_top;

    localparam int W = 32;
    localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_r = '0;
    logic [W-1:0] b_r = '0;
    logic [3:0]   ctrl_r = '0;
    logic [W-1:0] result;
    logic         zero, ovf, cout;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    alu_bitslice #(.WIDTH(W)) dut_i (
        .a_i(a_r), .b_i(b_r), .ctrl_i(ctrl_r),
        .result_o(result), .zero_o(zero), .overflow_o(ovf), .carry_o(cout)
    );

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (a=%h b=%h ctrl=%b)",
                     req, what, act, exp, a_r, b_r, ctrl_r);
        end
    endtask

    function automatic string req_of(logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            4'b1100: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c);
        logic [W-1:0] x, y, exp_res;
        logic [W:0]   s;
        logic         cin, exp_ovf;
        @(posedge clk);
        a_r = a; b_r = b; ctrl_r = c;
        #2;
        x   = c[3] ? ~a : a;
        y   = c[2] ? ~b : b;
        cin = c[2];
        s   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        exp_ovf = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
        case (c)
            4'b0000: exp_res = a & b;
            4'b0001: exp_res = a | b;
            4'b0010: exp_res = a + b;
            4'b0110: exp_res = a - b;
            4'b0111: exp_res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            4'b1100: exp_res = ~(a | b);
            default: begin
                case (c[1:0])
                    2'd0: exp_res = x & y;
                    2'd1: exp_res = x | y;
                    2'd2: exp_res = s[W-1:0];
                    default: exp_res = {{(W-1){1'b0}}, s[W-1] ^ exp_ovf};
                endcase
            end
        endcase
        check(req_of(c), "result", result, exp_res);
        check("R7", "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, exp_res == '0});
        check("R8", "overflow", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, exp_ovf});
        check("R10", "carry", {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, s[W]});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R7", "reset zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
        check("R1", "reset result", result, '0);
        rst_n = 1'b1;

        // Named corner cases
        apply(MINN, 32'd1, 4'b0111);   // R5: a-b overflows, a<b true
        check("R5", "slt under overflow", result, 32'd1);
        apply(MAXP, ONES, 4'b0111);    // R5: max > -1, a-b overflows
        check("R5", "slt max vs -1", result, 32'd0);
        apply(MAXP, 32'd1, 4'b0010);   // R8: positive overflow
        check("R8", "add overflow", {31'd0, ovf}, 32'd1);
        apply(ONES, 32'd1, 4'b0010);   // R3: carry out, zero result
        check("R3", "add wrap carry", {31'd0, cout}, 32'd1);
        apply(32'h1234, 32'h1234, 4'b0110); // R4 equal operands
        check("R4", "sub equal zero", {31'd0, zero}, 32'd1);
        apply(32'hF0F0_00FF, 32'h0FF0_0F0F, 4'b1101); // R9 NAND
        check("R9", "nand", result, ~(32'hF0F0_00FF & 32'h0FF0_0F0F));

        for (int c = 0; c < 16; c++) begin
            logic [W-1:0] corners [8];
            corners = '{32'd0, 32'd1, ONES, MAXP, MINN, 32'd6, 32'hFFFF_FFF9, 32'h5555_AAAA};
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    apply(corners[i], corners[j], 4'(c));
                end
            end
            for (int k = 0; k < 60; k++) begin
                logic [W-1:0] ra;
                ra = $urandom;
                apply(ra, (k % 5 == 0) ? ra : $urandom, 4'(c));
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule